// File: doc/BRIEF.md
# Selectable Clock Output Divider Bank

This block drives a small bank of divided clock outputs. Each output takes one of two reference sources and divides it. The slow reference is nominally 32768 Hz and the fast reference is nominally 4 MHz. Both references reach the block as single-cycle enable pulses ("ticks") on one fast system clock, so the outputs are registered levels in that clock domain.

Each output has its own 8-bit configuration register, written through a simple write port. The register holds four fields:
- an enable;
- a source select;
- a pre-divider code, which is used only when the fast source is selected;
- a power-of-two post-divider code.

The total divide N is the pre-divider factor times the post-divider factor. The output is high for the first N/2 source cycles of each period and low for the rest. A divide of 1 passes the source ticks straight through.

A configuration change never cuts a running period short. The new value is held until the current period ends, and the phase counter then starts again from zero.

The pins are plain control pins. The block has no streaming data path, so it has no valid/ready handshake.

Top module: `clkout_bank`

## Requirements
- R1: When the active configuration has bit 0 (enable) equal to 0, the output is low. After a disable has taken effect, the output stays low.
- R2: Bits 3:1 hold a post-divider code n. The post-divider divides by 2^n, for n from 0 to 7.
- R3: Bit 4 selects the source. A value of 0 selects the slow tick and a value of 1 selects the fast tick.
- R4: Bits 7:5 hold the pre-divider code for the fast source. Codes 0 to 6 divide by 2^code and code 7 divides by 122. The pre-divider factor multiplies the post-divider factor.
- R5: With the slow source selected, the pre-divider code is ignored and the total divide is 2^n.
- R6: Output i is configured by a write with `cfg_addr` equal to BASE_ADDR+i. A write to any other address changes no output.
- R7: While the active configuration is enabled, a new write is held until the next tick of the current source that would begin a new period.
  - That tick is consumed and the output goes low.
  - The phase counter restarts, and the first high phase of the new waveform starts on the next tick of the newly selected source.
  - While the output is disabled, a write takes effect on the next clock.
- R8: For a total divide N of 2 or more, consecutive rising edges are N source periods apart. The output is high for N/2 source periods and low for the rest. Between source ticks the output does not change.
- R9: For a total divide of 1, the output is high for exactly the clock cycle after each tick of the selected source.
- R10: After reset every configuration is zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse per slow reference period |
| fast_tick | input | 1 | One-cycle pulse per fast reference period |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | 8 | Configuration value: [0] enable, [3:1] post code, [4] source, [7:5] pre code |
| clk_out | output | NUM_OUT | Divided clock outputs, one per channel |

## Verification
The assertions assume the following about the inputs:
- The two tick inputs are sampled as one-cycle enables on the system clock.
- A write strobe lasts a single cycle.
- Reset is held for at least one rising edge before any traffic.

The stimulus meets these assumptions in four ways:
- It generates each tick from a free-running counter with a fixed spacing: every 7 cycles for the slow source and every 2 cycles for the fast source.
- It issues every write as an isolated one-cycle strobe, driven between clock edges.
- It places the write in the boundary scenario strictly inside a running period, so the period boundary that applies it is known in advance.
- It keeps the spacing of the slow ticks wider than one cycle, so the rule that the output holds between ticks can be observed.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  localparam int CFG_W        = 8;
  localparam int CODE_W       = 3;
  localparam int PRE_LAST_DIV = 122;
  localparam int POST_MAX_LOG = (1 << CODE_W) - 1;
  localparam int DIV_MAX      = PRE_LAST_DIV * (1 << POST_MAX_LOG);
  localparam int DIV_W        = $clog2(DIV_MAX + 1);

  // Field order matches the register layout, MSB first.
  typedef struct packed {
    logic [CODE_W-1:0] pre;
    logic              src_fast;
    logic [CODE_W-1:0] post;
    logic              en;
  } cfg_t;

  // Total divide for a configuration: pre factor (fast source only) times 2^post.
  function automatic logic [DIV_W-1:0] total_div(input cfg_t c);
    logic [DIV_W-1:0] pre_f;
    if (!c.src_fast)
      pre_f = DIV_W'(1);
    else if (c.pre == CODE_W'((1 << CODE_W) - 1))
      pre_f = DIV_W'(PRE_LAST_DIV);
    else
      pre_f = DIV_W'(1) << c.pre;
    return pre_f << c.post;
  endfunction

endpackage

// File: rtl/clkout_cfg_slot.sv
module clkout_cfg_slot
  import clkout_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  cfg_t wdata,
  input  logic boundary,
  output cfg_t act,
  output logic load
);

  cfg_t shadow;
  logic pending;

  // Apply at once when idle, otherwise only at a period boundary.
  assign load = pending && (!act.en || boundary);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow  <= '0;
      act     <= '0;
      pending <= 1'b0;
    end else begin
      if (wr)
        shadow <= wdata;
      if (load)
        act <= shadow;
      if (wr)
        pending <= 1'b1;
      else if (load)
        pending <= 1'b0;
    end
  end

  p_apply_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr) |=> !pending);

  p_act_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act));

endmodule

// File: rtl/clkout_wave.sv
module clkout_wave
  import clkout_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t act,
  input  logic load,
  input  logic slow_tick,
  input  logic fast_tick,
  output logic boundary,
  output logic clk_o
);

  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] hi_len;
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign div      = total_div(act);
  assign hi_len   = div >> 1;
  assign tick     = act.src_fast ? fast_tick : slow_tick;
  assign boundary = act.en && tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      clk_o <= 1'b0;
    end else if (load || !act.en) begin
      cnt   <= '0;
      clk_o <= 1'b0;
    end else if (div == DIV_W'(1)) begin
      cnt   <= '0;
      clk_o <= tick;
    end else if (tick) begin
      clk_o <= (cnt < hi_len);
      cnt   <= (cnt == div - DIV_W'(1)) ? '0 : cnt + DIV_W'(1);
    end
  end

  p_off_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !act.en |=> !clk_o);

  p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    act.en |-> (cnt < div));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act.en && div != DIV_W'(1) && !tick && !load) |=> $stable(clk_o));

  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act.en && div == DIV_W'(1) && !load) |=> (clk_o == $past(tick)));

endmodule

// File: rtl/clkout_bank.sv
module clkout_bank
  import clkout_pkg::*;
#(
  parameter int NUM_OUT   = 3,
  parameter int ADDR_W    = 4,
  parameter int BASE_ADDR = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slow_tick,
  input  logic               fast_tick,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [NUM_OUT-1:0] clk_out
);

  logic [NUM_OUT-1:0] sel;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_ch
    cfg_t act;
    logic load;
    logic boundary;

    assign sel[i] = cfg_we && (cfg_addr == ADDR_W'(BASE_ADDR + i));

    clkout_cfg_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (sel[i]),
      .wdata    (cfg_t'(cfg_wdata)),
      .boundary (boundary),
      .act      (act),
      .load     (load)
    );

    clkout_wave u_wave (
      .clk       (clk),
      .rst_n     (rst_n),
      .act       (act),
      .load      (load),
      .slow_tick (slow_tick),
      .fast_tick (fast_tick),
      .boundary  (boundary),
      .clk_o     (clk_out[i])
    );
  end

  p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

endmodule

// File: tb/clkout_bank_test.sv
module clkout_bank_test;

  localparam int NUM_OUT = 3;
  localparam int ADDR_W  = 4;
  localparam int SLOW_P  = 7;
  localparam int FAST_P  = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               slow_tick = 1'b0;
  logic               fast_tick = 1'b0;
  logic               cfg_we = 1'b0;
  logic [ADDR_W-1:0]  cfg_addr = '0;
  logic [7:0]         cfg_wdata = '0;
  logic [NUM_OUT-1:0] clk_out;

  int total = 0;
  int bad = 0;
  int tcnt = 0;

  clkout_bank #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W), .BASE_ADDR(0)) uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .clk_out(clk_out)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tcnt++;
    slow_tick = (tcnt % SLOW_P) == 0;
    fast_tick = (tcnt % FAST_P) == 0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int addr, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = ADDR_W'(addr); cfg_wdata = 8'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_rise(input int ch, output bit ok);
    bit prev;
    prev = clk_out[ch];
    ok = 0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (clk_out[ch] && !prev) begin ok = 1; break; end
      prev = clk_out[ch];
    end
  endtask

  task automatic measure(input int ch, input int ep, input int eh, input string req);
    bit ok; bit prev; bit cur; int per; int hi;
    wait_rise(ch, ok);
    if (ok) wait_rise(ch, ok);
    per = 0; hi = 1; prev = 1;
    if (ok) begin
      ok = 0;
      for (int k = 0; k < 4000; k++) begin
        @(negedge clk);
        per++;
        cur = clk_out[ch];
        if (cur && !prev) begin ok = 1; break; end
        if (cur) hi++;
        prev = cur;
      end
    end
    check(ok && per == ep, {req, " period"}, per, ep);
    check(ok && hi == eh, {req, " high time"}, hi, eh);
  endtask

  task automatic stay_low(input int cycles, input string req);
    int seen = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (clk_out != '0) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  // R10: reset state
  task automatic t_reset;
    for (int c = 0; c < NUM_OUT; c++) check(clk_out[c] == 1'b0, "R10 reset output", clk_out[c], 0);
    stay_low(40, "R10 idle after reset");
  endtask

  // R2/R3/R8/R9 on the slow source
  task automatic t_slow_post;
    write_cfg(0, 8'h01);
    measure(0, SLOW_P, 1, "R9 slow pass-through n=0");
    write_cfg(0, 8'h0F);
    measure(0, 128 * SLOW_P, 64 * SLOW_P, "R2 slow n=7");
    write_cfg(0, 8'h05);
    measure(0, 4 * SLOW_P, 2 * SLOW_P, "R8 R3 slow n=2");
    check(clk_out[1] == 1'b0, "R6 untouched channel", clk_out[1], 0);
  endtask

  // R7: change while running, applied at period boundary
  task automatic t_boundary;
    bit ok; bit prev; bit cur; int per; int hi;
    wait_rise(0, ok);
    per = 0; hi = 1; prev = 1;
    if (ok) begin
      ok = 0;
      for (int k = 0; k < 4000; k++) begin
        @(negedge clk);
        per++;
        if (per == 2) begin cfg_we = 1'b1; cfg_addr = '0; cfg_wdata = 8'h03; end
        if (per == 3) cfg_we = 1'b0;
        cur = clk_out[0];
        if (cur && !prev) begin ok = 1; break; end
        if (cur) hi++;
        prev = cur;
      end
    end
    check(ok && hi == 2 * SLOW_P, "R7 old high kept", hi, 2 * SLOW_P);
    check(ok && per == 5 * SLOW_P, "R7 restart after boundary", per, 5 * SLOW_P);
    measure(0, 2 * SLOW_P, SLOW_P, "R7 new divide");
  endtask

  // R5: pre code ignored on slow source
  task automatic t_slow_bypass;
    write_cfg(1, 8'hE3);
    measure(1, 2 * SLOW_P, SLOW_P, "R5 slow ignores pre");
  endtask

  // R4/R3 on the fast source
  task automatic t_fast_pre;
    write_cfg(2, 8'h71);
    measure(2, 8 * FAST_P, 4 * FAST_P, "R4 fast pre=8");
    write_cfg(2, 8'h35);
    measure(2, 8 * FAST_P, 4 * FAST_P, "R4 fast pre=2 post=4");
    write_cfg(2, 8'hF1);
    measure(2, 122 * FAST_P, 61 * FAST_P, "R4 fast pre=122");
    write_cfg(2, 8'h11);
    measure(2, FAST_P, 1, "R9 R3 fast pass-through");
  endtask

  // R1: disable holds output low
  task automatic t_disable;
    for (int c = 0; c < NUM_OUT; c++) write_cfg(c, 8'h00);
    repeat (300) @(negedge clk);
    stay_low(200, "R1 disabled low");
  endtask

  // R6: unused address ignored
  task automatic t_addr;
    write_cfg(NUM_OUT, 8'h01);
    stay_low(200, "R6 stray address ignored");
    write_cfg(1, 8'h01);
    measure(1, SLOW_P, 1, "R6 own address");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_slow_post();
    t_boundary();
    t_slow_bypass();
    t_fast_pre();
    t_disable();
    t_addr();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule